// File: doc/BRIEF.md
# Resumable Word Copy Engine

This block copies a run of words from one memory region to another over a single request/acknowledge memory port. Software gives it a source base, a destination base and a word count, then pulses a start strobe. For each word the engine issues one read from the source, then one write of that data to the destination. Both addresses then step up by one word and the remaining count drops by one. A one-cycle done pulse marks the end of the run.

A copy can be broken off part-way by an interrupt strobe. The engine never stops between a read and its write. It always finishes the word it is carrying. It then parks its next source address, next destination address and remaining count in a single internal save slot, sets a save-valid flag and pulses an interrupt acknowledge. A later resume strobe reloads the slot and carries on from the next unread source word. Because no word is ever fetched twice, the engine can drain a read-sensitive source such as a FIFO-mapped register without losing or repeating data. Only one interrupt level exists, so there is only one slot.

Top module: `blkcopy_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o`, `mem_req_o`, `done_o`, `int_ack_o` and `save_valid_o` are all low.
- R2: A start with a nonzero count performs, for word i (counting from 0), a read at source base + i, then a write at destination base + i carrying exactly the data that read returned. A request (`mem_req_o` high, with `mem_we_o` 0 for a read and 1 for a write) holds its address and direction until `mem_ack_i` is sampled high at a clock edge. `mem_rdata_i` is taken at that same edge.
- R3: `done_o` is high for exactly one cycle, in the cycle after the edge that acknowledges the final write. After that the engine is idle (`busy_o` low).
- R4: A start with a count of zero raises `done_o` in the cycle after the start edge and issues no memory request.
- R5: An interrupt is taken only between words. A read that is already under way is completed together with its write before the engine parks. The saved source and destination equal the next addresses to use, and the saved count equals the words still to copy, which is never zero.
- R6: `int_ack_o` pulses for one cycle once the state is parked. `save_valid_o` is already high in that cycle and `busy_o` is low.
- R7: A resume strobe while idle with `save_valid_o` high reloads the saved state, clears `save_valid_o` and continues. Across any number of interrupt/resume rounds, every source word is read exactly once and in order.
- R8: A resume with `save_valid_o` low, and a start while a copy is running, are both ignored.
- R9: An interrupt that arrives while the last word is in flight does not park the engine. The copy ends with `done_o`, no acknowledge is given, and `save_valid_o` stays low.
- R10: An interrupt strobe while the engine is idle is ignored: no acknowledge is given and `save_valid_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled only while idle |
| src_base_i | input | ADDR_W | First source word address |
| dst_base_i | input | ADDR_W | First destination word address |
| word_cnt_i | input | CNT_W | Number of words to copy |
| irq_i | input | 1 | Interrupt strobe |
| resume_i | input | 1 | Resume strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the current request |
| mem_rdata_i | input | DATA_W | Read data, valid while acknowledged |
| busy_o | output | 1 | Engine is copying or parking |
| done_o | output | 1 | One-cycle completion pulse |
| int_ack_o | output | 1 | One-cycle pulse after state is parked |
| save_valid_o | output | 1 | Save slot holds a parked copy |
| saved_src_o | output | ADDR_W | Parked next source address |
| saved_dst_o | output | ADDR_W | Parked next destination address |
| saved_cnt_o | output | CNT_W | Parked remaining word count |

## Verification
The hardest case to reach from the ports is an interrupt that lands between a read acknowledge and the matching write acknowledge. This must be combined with a memory that stalls for a varying number of cycles, and with a second interrupt arriving soon after a resume. The bench sweeps every copy length from 1 to 6 against interrupt delays of 0 to 9 cycles, and re-interrupts after each resume with a shifting delay. A pseudo-random stall pattern on the acknowledge moves the interrupt across every phase of a word. The source model is a FIFO whose data value is the pop index, so any repeated or skipped fetch shows up as wrong write data or a wrong pop total.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_WRITE = 2'd2,
    CP_PARK  = 2'd3
  } cp_state_e;

endpackage

// File: rtl/blkcopy_ctx.sv
// Live copy context: next addresses, remaining count and the word in flight.
module blkcopy_ctx #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              step_en,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [DATA_W-1:0] cur_data,
  output logic              last_word
);

  logic [ADDR_W-1:0] src_d, dst_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              pos_en;

  always_comb begin
    pos_en = load_en | step_en;
    if (load_en) begin
      src_d = load_src;
      dst_d = load_dst;
      cnt_d = load_cnt;
    end else begin
      src_d = cur_src + ADDR_W'(1);
      dst_d = cur_dst + ADDR_W'(1);
      cnt_d = cur_cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
    end else if (pos_en) begin
      cur_src <= src_d;
      cur_dst <= dst_d;
      cur_cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_data <= '0;
    else if (cap_en) cur_data <= cap_data;
  end

  assign last_word = (cur_cnt == CNT_W'(1));

endmodule

// File: rtl/blkcopy_slot.sv
// Single save slot for one parked copy.
module blkcopy_slot #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic              valid,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic [CNT_W-1:0]  out_cnt
);

  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (wr_en)       valid_d = 1'b1;
    else if (clr_en) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_src <= '0;
      out_dst <= '0;
      out_cnt <= '0;
    end else if (wr_en) begin
      out_src <= in_src;
      out_dst <= in_dst;
      out_cnt <= in_cnt;
    end
  end

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic              irq_i,
  input  logic              resume_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              int_ack_o,
  output logic              save_valid_o,
  output logic [ADDR_W-1:0] saved_src_o,
  output logic [ADDR_W-1:0] saved_dst_o,
  output logic [CNT_W-1:0]  saved_cnt_o
);

  cp_state_e         state_q, state_d;
  logic              irq_pend_q, irq_pend_d;
  logic              done_d, ack_d;
  logic              load_en, from_slot, cap_en, step_en, slot_wr, slot_clr;
  logic [ADDR_W-1:0] cur_src, cur_dst, ld_src, ld_dst;
  logic [CNT_W-1:0]  cur_cnt, ld_cnt;
  logic [DATA_W-1:0] cur_data;
  logic              last_word, in_copy;

  assign ld_src = from_slot ? saved_src_o : src_base_i;
  assign ld_dst = from_slot ? saved_dst_o : dst_base_i;
  assign ld_cnt = from_slot ? saved_cnt_o : word_cnt_i;

  blkcopy_ctx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_src  (ld_src),
    .load_dst  (ld_dst),
    .load_cnt  (ld_cnt),
    .cap_en    (cap_en),
    .cap_data  (mem_rdata_i),
    .step_en   (step_en),
    .cur_src   (cur_src),
    .cur_dst   (cur_dst),
    .cur_cnt   (cur_cnt),
    .cur_data  (cur_data),
    .last_word (last_word)
  );

  blkcopy_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (slot_wr),
    .clr_en  (slot_clr),
    .in_src  (cur_src),
    .in_dst  (cur_dst),
    .in_cnt  (cur_cnt),
    .valid   (save_valid_o),
    .out_src (saved_src_o),
    .out_dst (saved_dst_o),
    .out_cnt (saved_cnt_o)
  );

  assign in_copy = (state_q == CP_READ) || (state_q == CP_WRITE);

  // Next-state and control decode
  always_comb begin
    state_d   = state_q;
    load_en   = 1'b0;
    from_slot = 1'b0;
    cap_en    = 1'b0;
    step_en   = 1'b0;
    slot_wr   = 1'b0;
    slot_clr  = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      CP_IDLE: begin
        if (start_i) begin
          if (word_cnt_i == '0) begin
            done_d = 1'b1;
          end else begin
            load_en = 1'b1;
            state_d = CP_READ;
          end
        end else if (resume_i && save_valid_o) begin
          load_en   = 1'b1;
          from_slot = 1'b1;
          slot_clr  = 1'b1;
          state_d   = CP_READ;
        end
      end
      CP_READ: begin
        if (mem_ack_i) begin
          cap_en  = 1'b1;
          state_d = CP_WRITE;
        end
      end
      CP_WRITE: begin
        if (mem_ack_i) begin
          step_en = 1'b1;
          if (last_word) begin
            done_d  = 1'b1;
            state_d = CP_IDLE;
          end else if (irq_pend_q || irq_i) begin
            state_d = CP_PARK;
          end else begin
            state_d = CP_READ;
          end
        end
      end
      CP_PARK: begin
        slot_wr = 1'b1;
        state_d = CP_IDLE;
      end
      default: state_d = CP_IDLE;
    endcase
  end

  // An interrupt is held until the word in flight has been written
  always_comb begin
    irq_pend_d = 1'b0;
    if (in_copy) begin
      irq_pend_d = irq_pend_q | irq_i;
      if ((state_q == CP_WRITE) && mem_ack_i) irq_pend_d = 1'b0;
    end
  end

  assign ack_d = (state_q == CP_PARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CP_IDLE;
      irq_pend_q <= 1'b0;
      done_o     <= 1'b0;
      int_ack_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      irq_pend_q <= irq_pend_d;
      done_o     <= done_d;
      int_ack_o  <= ack_d;
    end
  end

  assign mem_req_o   = in_copy;
  assign mem_we_o    = (state_q == CP_WRITE);
  assign mem_addr_o  = (state_q == CP_WRITE) ? cur_dst : cur_src;
  assign mem_wdata_o = cur_data;
  assign busy_o      = (state_q != CP_IDLE);

endmodule

// File: rtl/blkcopy_checker.sv
module blkcopy_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              resume_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              int_ack_o,
  input logic              save_valid_o,
  input logic [CNT_W-1:0]  saved_cnt_o
);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  assert_saved_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack_o |-> (saved_cnt_o != '0));

  assert_ack_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack_o |-> (save_valid_o && !busy_o));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack_o |=> !int_ack_o);

  assert_valid_rise_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_valid_o) |-> int_ack_o);

  assert_resume_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_i && !save_valid_o && !start_i && !busy_o) |=> !busy_o);

endmodule

bind blkcopy_engine blkcopy_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .resume_i     (resume_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .int_ack_o    (int_ack_o),
  .save_valid_o (save_valid_o),
  .saved_cnt_o  (saved_cnt_o)
);

// File: tb/blkcopy_engine_tb.sv
`timescale 1ns/100ps
module blkcopy_engine_tb;

  localparam int AW = 8;
  localparam int CW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, irq_i, resume_i;
  logic [AW-1:0] src_base_i, dst_base_i;
  logic [CW-1:0] word_cnt_i;
  logic          mem_req_o, mem_we_o, mem_ack_i;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic          busy_o, done_o, int_ack_o, save_valid_o;
  logic [AW-1:0] saved_src_o, saved_dst_o;
  logic [CW-1:0] saved_cnt_o;

  always #2 clk = ~clk;

  blkcopy_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_base_i(src_base_i),
    .dst_base_i(dst_base_i), .word_cnt_i(word_cnt_i), .irq_i(irq_i),
    .resume_i(resume_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .int_ack_o(int_ack_o), .save_valid_o(save_valid_o),
    .saved_src_o(saved_src_o), .saved_dst_o(saved_dst_o), .saved_cnt_o(saved_cnt_o)
  );

  int n_chk = 0, n_fail = 0;
  int m_chk = 0, m_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int rd_base = 0, wr_base = 0;
  int done_cnt = 0, ack_cnt = 0;
  int run_id = 0;
  logic [AW-1:0] src0 = '0, dst0 = '0;
  logic [7:0]    lfsr;

  function automatic logic [DW-1:0] fifo_val(input int rid, input int idx);
    return DW'(16'h1000 + rid * 64 + idx);
  endfunction

  // FIFO-mapped source: data is the pop index, each acknowledged read pops
  assign mem_rdata_i = fifo_val(run_id, rd_cnt - rd_base);
  assign mem_ack_i   = mem_req_o && !(lfsr[0] && lfsr[1]);

  always @(posedge clk) begin
    if (!rst_n) lfsr <= 8'h5B;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  // Memory model with per-access checks (R2, R7)
  always @(posedge clk) begin
    if (rst_n && mem_req_o && mem_ack_i) begin
      m_chk <= m_chk + 1;
      if (!mem_we_o) begin
        if (mem_addr_o !== AW'(src0 + (rd_cnt - rd_base))) begin
          m_fail <= m_fail + 1;
          $display("FAIL R2 read addr: actual %0h expected %0h", mem_addr_o,
                   AW'(src0 + (rd_cnt - rd_base)));
        end
        rd_cnt <= rd_cnt + 1;
      end else begin
        if (mem_addr_o !== AW'(dst0 + (wr_cnt - wr_base)) ||
            mem_wdata_o !== fifo_val(run_id, wr_cnt - wr_base)) begin
          m_fail <= m_fail + 1;
          $display("FAIL R7 write addr/data: actual %0h/%0h expected %0h/%0h",
                   mem_addr_o, mem_wdata_o, AW'(dst0 + (wr_cnt - wr_base)),
                   fifo_val(run_id, wr_cnt - wr_base));
        end
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (done_o)    done_cnt = done_cnt + 1;
    if (int_ack_o) ack_cnt  = ack_cnt + 1;
  end

  task automatic tick();
    @(negedge clk);
    #0.2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
    $finish;
  endtask

  task automatic issue_start(input int len, input int sb, input int db);
    start_i    = 1'b1;
    src_base_i = AW'(sb);
    dst_base_i = AW'(db);
    word_cnt_i = CW'(len);
    tick();
    start_i = 1'b0;
  endtask

  task automatic prep_run(input int sb, input int db);
    run_id++;
    src0    = AW'(sb);
    dst0    = AW'(db);
    rd_base = rd_cnt;
    wr_base = wr_cnt;
  endtask

  task automatic wait_evt(input int pd, input int pa);
    for (int i = 0; i < 300; i++) begin
      if (done_cnt != pd || ack_cnt != pa) break;
      tick();
    end
  endtask

  // One copy with interrupts d0 cycles after start and shifting delays after each resume
  task automatic run_copy(input int len, input int d0);
    int pd, pa, d;
    prep_run(16 + len * 8, 128 + d0 * 4);
    pd = done_cnt;
    pa = ack_cnt;
    issue_start(len, src0, dst0);
    d = d0;
    for (int r = 0; r < 40 && done_cnt == pd; r++) begin
      repeat (d) tick();
      irq_i = 1'b1;
      tick();
      irq_i = 1'b0;
      wait_evt(pd, pa);
      if (ack_cnt != pa) begin
        pa = ack_cnt;
        chk(save_valid_o === 1'b1 && busy_o === 1'b0, "R6 valid at ack", save_valid_o, 1);
        chk(rd_cnt - rd_base == wr_cnt - wr_base, "R5 word boundary", rd_cnt - rd_base, wr_cnt - wr_base);
        chk(saved_src_o === AW'(src0 + (rd_cnt - rd_base)), "R5 saved src", saved_src_o,
            AW'(src0 + (rd_cnt - rd_base)));
        chk(saved_dst_o === AW'(dst0 + (wr_cnt - wr_base)), "R5 saved dst", saved_dst_o,
            AW'(dst0 + (wr_cnt - wr_base)));
        chk(saved_cnt_o === CW'(len - (wr_cnt - wr_base)), "R5 saved count", saved_cnt_o,
            len - (wr_cnt - wr_base));
        tick();
        resume_i = 1'b1;
        tick();
        resume_i = 1'b0;
        chk(save_valid_o === 1'b0 && busy_o === 1'b1, "R7 resume reload", save_valid_o, 0);
      end
      d = (d % 4) + 1;
    end
    repeat (3) tick();
    chk(done_cnt == pd + 1, "R3 one done per copy", done_cnt - pd, 1);
    chk(rd_cnt - rd_base == len, "R7 pops exactly once", rd_cnt - rd_base, len);
    chk(wr_cnt - wr_base == len, "R2 writes", wr_cnt - wr_base, len);
    chk(ack_cnt == pa && busy_o === 1'b0, "R10 no late ack", ack_cnt - pa, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int pd, pa, pr;
    rst_n = 1'b0; start_i = 1'b0; irq_i = 1'b0; resume_i = 1'b0;
    src_base_i = '0; dst_base_i = '0; word_cnt_i = '0;
    repeat (3) tick();
    chk(busy_o === 1'b0 && mem_req_o === 1'b0 && done_o === 1'b0 &&
        int_ack_o === 1'b0 && save_valid_o === 1'b0, "R1 in reset", busy_o, 0);
    rst_n = 1'b1;
    tick();
    chk(busy_o === 1'b0 && mem_req_o === 1'b0 && done_o === 1'b0 &&
        int_ack_o === 1'b0 && save_valid_o === 1'b0, "R1 after reset", mem_req_o, 0);

    // R8: resume with empty slot
    pr = rd_cnt + wr_cnt;
    resume_i = 1'b1;
    tick();
    resume_i = 1'b0;
    chk(busy_o === 1'b0, "R8 resume ignored busy", busy_o, 0);
    tick();
    chk(rd_cnt + wr_cnt == pr && save_valid_o === 1'b0, "R8 resume ignored mem", rd_cnt + wr_cnt - pr, 0);

    // R10: interrupt while idle
    pa = ack_cnt;
    irq_i = 1'b1;
    tick();
    irq_i = 1'b0;
    repeat (3) tick();
    chk(ack_cnt == pa && save_valid_o === 1'b0, "R10 idle irq ignored", ack_cnt - pa, 0);

    // R4: zero-length copy
    pd = done_cnt;
    pr = rd_cnt + wr_cnt;
    issue_start(0, 8'h20, 8'h40);
    chk(done_o === 1'b1, "R4 zero length done", done_o, 1);
    tick();
    chk(done_o === 1'b0 && busy_o === 1'b0, "R3 done single cycle", done_o, 0);
    repeat (2) tick();
    chk(rd_cnt + wr_cnt == pr, "R4 no memory access", rd_cnt + wr_cnt - pr, 0);

    // R8: start while busy is ignored
    prep_run(8'h30, 8'h70);
    pd = done_cnt;
    issue_start(5, 8'h30, 8'h70);
    repeat (3) tick();
    issue_start(3, 8'hA0, 8'hB0);
    wait_evt(pd, ack_cnt);
    repeat (2) tick();
    chk(rd_cnt - rd_base == 5 && wr_cnt - wr_base == 5, "R8 start while busy", wr_cnt - wr_base, 5);

    // R9: interrupt during the only word
    prep_run(8'h50, 8'h60);
    pd = done_cnt;
    pa = ack_cnt;
    issue_start(1, 8'h50, 8'h60);
    irq_i = 1'b1;
    tick();
    irq_i = 1'b0;
    wait_evt(pd, pa);
    repeat (3) tick();
    chk(done_cnt == pd + 1 && ack_cnt == pa, "R9 last word completes", ack_cnt - pa, 0);
    chk(save_valid_o === 1'b0, "R9 no park", save_valid_o, 0);

    // Sweep: lengths and interrupt timings (R2, R3, R5, R6, R7)
    for (int len = 1; len <= 6; len++) begin
      for (int d0 = 0; d0 <= 9; d0++) begin
        run_copy(len, d0);
      end
    end

    summary();
  end

endmodule